// File: doc/BRIEF.md
# Hotspot-Clocked Two-Wire Serial Port

This block is a two-wire serial port for a bank-switched cartridge that the processor runs purely through bus accesses. It has no shift register and no data register. The block watches the cartridge address bus for four neighbouring zero-page addresses. A bus cycle that touches one of these addresses does one of four things: it raises the serial clock for that cycle, sets the data line, toggles the data line, or copies the data line into an address bit of the upper bank.

The processor reads the serial data back indirectly. A sample of the data pin is steered into bit 8 of the upper bank address, so the value shows up as a change in the bytes the processor fetches from that bank. Indexed zero-page instructions perform a dummy read of the base address before the real access. That dummy read lands on one hotspot and the real access lands on the next, so a single instruction can both clock a bit and present the next data value.

The block runs on a clock at four times the bus rate. A phase counter splits every bus cycle into four phases. Bus inputs must be stable for all four phases of a cycle.

Top module: `hotspot_i2c_port`

## Requirements
- R1: While reset is asserted and on the first sample after it, `sck` is 0, `sda_oe` is 0 (line released) and `bank_a8` is 0.
- R2: A read or a write at address base+1 ($6D) raises `sck` on the first clock edge of that bus cycle. `sck` stays high for exactly four clocks and does not change the data line.
- R3: An access at base+3 ($6F) gives the same four-clock `sck` pulse as R2 and inverts the data line level.
- R4: A write (`bus_rw`=0) at base+2 ($6E) sets the data line level to `bus_data[7]`. Level 1 means released (`sda_oe`=0) and level 0 means driven low (`sda_oe`=1).
- R5: A read (`bus_rw`=1) at base+2 ($6E) sets the data line level to 0 (`sda_oe`=1), whatever is on `bus_data`.
- R6: Any data line change made by a bus cycle appears on the third clock edge of that cycle. `sda_oe` holds its old value for the first two clocks of the cycle.
- R7: An access at base ($6C) loads `bank_a8` on the first edge of the cycle with the `sda_in` value that was present between the second and third edges of the previous bus cycle (a two-flop synchronizer). `bank_a8` holds until the next such access.
- R8: Hotspot accesses in adjacent bus cycles each take their own effect. For example, a $6D cycle followed by a $6E write gives one clock pulse and then the new data level.
- R9: Addresses outside the four hotspots, including base-1 ($6B) and base+4 ($70), leave `sck`, `sda_oe` and `bank_a8` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four periods per bus cycle |
| rst | input | 1 | Synchronous active-high reset; phase 0 follows it |
| bus_addr | input | 13 | Cartridge address bus |
| bus_data | input | 8 | Data bus (bit 7 used on writes) |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| sda_in | input | 1 | Serial data pin level |
| sck | output | 1 | Serial clock to the EEPROM |
| sda_oe | output | 1 | 1 = pull data line low, 0 = release |
| bank_a8 | output | 1 | Bit 8 of the upper bank address |

## Verification
The bench goes after the timing of the data change inside a cycle. A design that applied it at the first edge would move `sda_oe` two clocks early and fail R6. It runs back-to-back clock and data cycles, where a design that held only one pending action would drop the second effect. It checks the read form of $6E against writes that carry bit 7 set, to catch a design that ignores `bus_rw`. It also checks the sampling delay of $6C against a data line that moved in the previous cycle, so a missing or extra synchronizer stage latches the wrong level. Random cycles with a weak external pull-down mixed in check the neighbouring non-hotspot addresses against a bench model.

// File: rtl/hs_pkg.sv
package hs_pkg;

    // Action requested by the bus cycle currently on the bus.
    typedef enum logic [2:0] {
        HS_NONE   = 3'd0,
        HS_SAMPLE = 3'd1,
        HS_CLK    = 3'd2,
        HS_SET    = 3'd3,
        HS_CLKTOG = 3'd4
    } hs_op_t;

    typedef struct packed {
        hs_op_t op;
        logic   lvl;   // level for HS_SET
    } hs_req_t;

    localparam hs_req_t HS_IDLE = '{op: HS_NONE, lvl: 1'b1};

    function automatic logic hs_pulses(input hs_op_t op);
        return (op == HS_CLK) || (op == HS_CLKTOG);
    endfunction

endpackage

// File: rtl/hs_phase.sv
module hs_phase #(
    parameter int PHASES = 4,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    always_ff @(posedge clk) begin
        if (rst || ph == PH_LAST) ph <= '0;
        else                      ph <= ph + 1'b1;
    end
endmodule

// File: rtl/hs_decode.sv
module hs_decode
    import hs_pkg::*;
#(
    parameter int               ADDR_W   = 13,
    parameter logic [ADDR_W-1:0] HOT_BASE = 13'h006C
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic              rw,
    output hs_req_t           req
);
    localparam int NHOT = 4;
    logic [NHOT-1:0] hit;

    for (genvar i = 0; i < NHOT; i++) begin : g_hit
        assign hit[i] = (addr == HOT_BASE + ADDR_W'(i));
    end

    always_comb begin
        req = HS_IDLE;
        unique case (1'b1)
            hit[0]: req.op = HS_SAMPLE;
            hit[1]: req.op = HS_CLK;
            hit[2]: begin
                req.op  = HS_SET;
                req.lvl = rw ? 1'b0 : data[7];
            end
            hit[3]: req.op = HS_CLKTOG;
            default: req = HS_IDLE;
        endcase
    end
endmodule

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st;

    for (genvar i = 0; i < STAGES; i++) begin : g_st
        always_ff @(posedge clk) begin
            if (rst)         st[i] <= INIT;
            else if (i == 0) st[i] <= d;
            else             st[i] <= st[(i > 0) ? i - 1 : 0];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/hotspot_i2c_port.sv
module hotspot_i2c_port
    import hs_pkg::*;
#(
    parameter int               ADDR_W      = 13,
    parameter logic [ADDR_W-1:0] HOT_BASE    = 13'h006C,
    parameter int               PHASES      = 4,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    input  logic              bus_rw,
    input  logic              sda_in,
    output logic              sck,
    output logic              sda_oe,
    output logic              bank_a8
);
    localparam int PH_W = $clog2(PHASES);
    // Edge index at three quarters of the bus cycle.
    localparam logic [PH_W-1:0] SDA_EDGE = PH_W'((PHASES * 3) / 4 - 1);

    logic [PH_W-1:0] ph;
    hs_req_t         cur, pend_q;
    logic            sda_s, sck_q, lvl_q, bank_q;

    hs_phase #(.PHASES(PHASES)) u_phase (.clk(clk), .rst(rst), .ph(ph));

    hs_decode #(.ADDR_W(ADDR_W), .HOT_BASE(HOT_BASE)) u_dec (
        .addr(bus_addr), .data(bus_data), .rw(bus_rw), .req(cur)
    );

    hs_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= HS_IDLE;
            sck_q  <= 1'b0;
            lvl_q  <= 1'b1;
            bank_q <= 1'b0;
        end else begin
            if (ph == '0) begin
                pend_q <= cur;
                sck_q  <= hs_pulses(cur.op);
                if (cur.op == HS_SAMPLE) bank_q <= sda_s;
            end
            if (ph == SDA_EDGE) begin
                case (pend_q.op)
                    HS_SET:    lvl_q <= pend_q.lvl;
                    HS_CLKTOG: lvl_q <= ~lvl_q;
                    default:   lvl_q <= lvl_q;
                endcase
            end
        end
    end

    assign sck     = sck_q;
    assign sda_oe  = ~lvl_q;
    assign bank_a8 = bank_q;

    // R2
    sck_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> $past(ph == '0 && hs_pulses(cur.op)));

    // R3
    sck_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sck) |-> $past(ph) == '0);

    // R2
    sck_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |=> sck ##1 sck ##1 sck);

    // R6
    sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(ph) == SDA_EDGE);

    // R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bank_a8) |-> $past(ph == '0 && cur.op == HS_SAMPLE));
endmodule

// File: tb/hotspot_i2c_port_test.sv
`timescale 1ns/1ps
module hotspot_i2c_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        bus_rw = 1'b1;
    logic        ext_low = 1'b0;
    logic        sda_in;
    logic        sck, sda_oe, bank_a8;

    int errors = 0;
    int checks = 0;

    // Model state
    logic exp_lvl = 1'b1;
    logic exp_bank = 1'b0;
    logic prev_mid = 1'b1;

    always #10 clk = ~clk;
    assign sda_in = ~(sda_oe | ext_low);

    hotspot_i2c_port uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_rw(bus_rw), .sda_in(sda_in), .sck(sck), .sda_oe(sda_oe),
        .bank_a8(bank_a8)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [12:0] a, input logic rw);
        case (a)
            13'h06C: return "R7";
            13'h06D: return "R2";
            13'h06E: return rw ? "R5" : "R4";
            13'h06F: return "R3";
            default: return "R9";
        endcase
    endfunction

    function automatic logic next_lvl(input logic [12:0] a, input logic rw,
                                      input logic [7:0] d, input logic lvl);
        if (a == 13'h06E) return rw ? 1'b0 : d[7];
        if (a == 13'h06F) return ~lvl;
        return lvl;
    endfunction

    // One bus cycle; called at a negedge just before the cycle's first edge.
    task automatic cyc(input logic [12:0] a, input logic rw, input logic [7:0] d,
                       input logic pull, input string ovr);
        logic  pulse, old_lvl, new_lvl, bank_new, mid;
        string t;
        t = (ovr != "") ? ovr : tag_of(a, rw);
        bus_addr = a; bus_rw = rw; bus_data = d; ext_low = pull;
        pulse    = (a == 13'h06D) || (a == 13'h06F);
        old_lvl  = exp_lvl;
        new_lvl  = next_lvl(a, rw, d, exp_lvl);
        bank_new = (a == 13'h06C) ? prev_mid : exp_bank;
        mid      = old_lvl & ~pull;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(t, "sck", sck, pulse);
            chk((k < 2) ? "R6" : t, "sda_oe", sda_oe, (k < 2) ? ~old_lvl : ~new_lvl);
            chk(t, "bank_a8", bank_a8, bank_new);
        end
        exp_lvl  = new_lvl;
        exp_bank = bank_new;
        prev_mid = mid;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "sck", sck, 1'b0);
        chk("R1", "sda_oe", sda_oe, 1'b0);
        chk("R1", "bank_a8", bank_a8, 1'b0);
        rst = 1'b0;
        cyc(13'h000, 1'b1, 8'h00, 1'b0, "R1");
        // Directed corner cases
        cyc(13'h06E, 1'b0, 8'h00, 1'b0, "");   // R4 drive low
        cyc(13'h06D, 1'b1, 8'hFF, 1'b0, "");   // R2 pulse, no sda change
        cyc(13'h06E, 1'b0, 8'h80, 1'b0, "");   // R4 release
        cyc(13'h06D, 1'b1, 8'h00, 1'b0, "R8"); // R8 dummy read then write
        cyc(13'h06E, 1'b0, 8'h00, 1'b0, "R8");
        cyc(13'h06E, 1'b0, 8'h80, 1'b0, "");
        cyc(13'h06E, 1'b1, 8'hFF, 1'b0, "");   // R5 read forces low
        cyc(13'h06F, 1'b1, 8'h00, 1'b0, "");   // R3 toggle to release
        cyc(13'h06F, 1'b0, 8'h00, 1'b0, "");   // R3 toggle to low
        cyc(13'h06F, 1'b0, 8'h00, 1'b1, "R8"); // release while pulled
        cyc(13'h06C, 1'b1, 8'h00, 1'b0, "");   // R7 sees pull-down -> 0
        cyc(13'h000, 1'b1, 8'h00, 1'b0, "");
        cyc(13'h06C, 1'b1, 8'h00, 1'b0, "");   // R7 sees released -> 1
        cyc(13'h06B, 1'b0, 8'h00, 1'b0, "");   // R9
        cyc(13'h070, 1'b0, 8'h00, 1'b0, "");   // R9
        cyc(13'h16E, 1'b0, 8'h00, 1'b0, "");   // R9 upper bits differ
        cyc(13'h06E, 1'b0, 8'h00, 1'b0, "R8"); // low, then sample next cycle
        cyc(13'h06C, 1'b1, 8'h00, 1'b0, "");   // R7 sees old released level
        cyc(13'h06C, 1'b1, 8'h00, 1'b0, "");   // R7 now sees low
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [12:0] a;
            int sel;
            sel = int'($urandom % 8);
            a = (sel < 6) ? 13'(13'h06B + sel) : 13'($urandom);
            cyc(a, 1'($urandom), 8'($urandom), ($urandom % 4) == 0, "");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule